// File: doc/BRIEF.md
# HDLC Transmit Idle and Preamble Sequencer

This block produces the serial transmit bit stream for one HDLC link, one bit per strobe. When no frame is waiting, the line carries an interframe fill chosen by a single select input. The fill is either steady ones or flag bytes sent back to back. When a payload byte is offered, the sequencer can first send a programmable 8-bit preamble a set number of times. It then sends an opening flag, the payload with zero-bit insertion, and a closing flag, and goes back to fill.

Payload arrives one byte at a time over a valid/ready/last handshake, and the sequencer pulls each byte at the exact bit slot where it needs it. If no byte is offered at that slot inside a frame, the frame is aborted with a run of seven ones. The bit strobe lets the block run at any bit rate below the clock rate. The output is a registered NRZ bit.

Top module: `hdlc_tx_seq`

## Requirements
- R1: While reset is held and right after it, `tx_bit` is 1 and `pay_ready` is 0.
- R2: With `fill_flags`=0 and no frame pending, every strobe emits a 1.
- R3: With `fill_flags`=1, idle emits the byte 0x7E repeatedly, least significant bit first. A frame waits until the current fill flag is complete before its first bit.
- R4: State and `tx_bit` advance only on cycles with `bit_en`=1. `tx_bit` holds its value otherwise.
- R5: With `pre_en`=0, the first bit after idle fill is the first bit of the opening flag 0x7E.
- R6: With `pre_en`=1, `pre_pattern` is sent least significant bit first, back to back, before the opening flag. It is sent 1, 2, 4 or 8 times for `pre_rep` = 00, 01, 10 or 11.
- R7: No zero is inserted inside the preamble, even for a pattern of all ones.
- R8: Payload bytes are taken on strobes with `pay_ready` and `pay_valid` both high and sent LSB first. After the byte flagged by `pay_last`, one closing flag 0x7E follows, then idle fill.
- R9: In the payload, a 0 is inserted after every five consecutive 1s, including runs that cross a byte boundary and a run that ends the last byte. The run count starts at zero for each frame.
- R10: If `pay_valid` is low at a strobe where `pay_ready` is high, the sequencer emits exactly seven 1s and then resumes idle fill.
- R11: `pre_en`, `pre_pattern` and `pre_rep` are captured when a frame starts. Changing them during the frame does not change its bits.
- R12: `pay_ready` is high only on strobe cycles in the payload phase, at the slot where the next byte (or abort) is decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit strobe; one output bit per high cycle |
| fill_flags | input | 1 | Idle fill select: 0 ones, 1 flag bytes |
| pre_en | input | 1 | Preamble insertion enable |
| pre_pattern | input | 8 | Preamble byte |
| pre_rep | input | 2 | Preamble copy count code |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte offered |
| pay_last | input | 1 | Offered byte is the last of the frame |
| pay_ready | output | 1 | Sequencer takes a byte this cycle |
| tx_bit | output | 1 | Serial NRZ output |

## Verification
Several rules are checked on every cycle: the output holds without a strobe, `pay_ready` appears only on payload strobes, a stuffed zero follows each run of five payload ones, abort bits are all ones, ones-fill emits ones, and the captured pattern stays unchanged during a frame. The scenarios alone can show the complete bit sequences. These are the preamble copy counts, the LSB-first order of flags, preamble and payload, the alignment of a frame start to the flag-fill boundary, the exact seven-bit abort length, and the immunity of a frame to configuration changes in mid-frame.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_OPEN,
        ST_DATA,
        ST_CLOSE,
        ST_ABORT
    } tx_state_e;
endpackage

// File: rtl/hdlc_tx_rep_decode.sv
module hdlc_tx_rep_decode #(
    parameter int REP_W = 2,
    parameter int CNT_W = (1 << REP_W) - 1
) (
    input  logic [REP_W-1:0] code,
    output logic [CNT_W-1:0] last_copy
);
    // copies = 2**code; the counter holds copies-1
    assign last_copy = CNT_W'((1 << code) - 1);
endmodule

// File: rtl/hdlc_tx_ones_track.sv
module hdlc_tx_ones_track #(
    parameter int RUN_LEN = 5,
    parameter int W       = $clog2(RUN_LEN + 1)
) (
    input  logic [W-1:0] ones_q,
    input  logic         bit_in,
    output logic         stuff_due,
    output logic [W-1:0] ones_next
);
    assign stuff_due = (ones_q == W'(RUN_LEN));
    assign ones_next = bit_in ? ones_q + W'(1) : '0;
endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
    import hdlc_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int REP_W     = 2,
    parameter int RUN_LEN   = 5,
    parameter int ABORT_LEN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fill_flags,
    input  logic              pre_en,
    input  logic [BYTE_W-1:0] pre_pattern,
    input  logic [REP_W-1:0]  pre_rep,
    input  logic [BYTE_W-1:0] pay_data,
    input  logic              pay_valid,
    input  logic              pay_last,
    output logic              pay_ready,
    output logic              tx_bit
);
    localparam int SEL_W  = $clog2(BYTE_W);
    localparam int IDX_W  = SEL_W + 1;
    localparam int AB_W   = $clog2(ABORT_LEN + 1);
    localparam int POS_W  = (IDX_W > AB_W) ? IDX_W : AB_W;
    localparam int CNT_W  = (1 << REP_W) - 1;
    localparam int ONES_W = $clog2(RUN_LEN + 1);
    localparam logic [BYTE_W-1:0] FLAG = {1'b0, {(BYTE_W-2){1'b1}}, 1'b0};

    typedef struct packed {
        tx_state_e         st;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] pat;
        logic [POS_W-1:0]  pos;
        logic [CNT_W-1:0]  rep;
        logic [ONES_W-1:0] ones;
        logic              last;
        logic              tx;
    } seq_t;

    seq_t q, d;
    logic              ready_d;
    logic [SEL_W-1:0]  sel;
    logic              sel_end;
    logic              fetch_slot;
    logic              data_bit;
    logic              stuff_due;
    logic [ONES_W-1:0] ones_next;
    logic [CNT_W-1:0]  rep_last;

    hdlc_tx_rep_decode #(.REP_W(REP_W), .CNT_W(CNT_W)) u_rep (
        .code      (pre_rep),
        .last_copy (rep_last)
    );

    assign sel        = q.pos[SEL_W-1:0];
    assign sel_end    = (sel == SEL_W'(BYTE_W - 1));
    assign fetch_slot = (q.pos == POS_W'(BYTE_W));
    assign data_bit   = fetch_slot ? pay_data[0] : q.sh[sel];

    hdlc_tx_ones_track #(.RUN_LEN(RUN_LEN), .W(ONES_W)) u_ones (
        .ones_q    (q.ones),
        .bit_in    (data_bit),
        .stuff_due (stuff_due),
        .ones_next (ones_next)
    );

    always_comb begin
        d       = q;
        ready_d = 1'b0;
        if (bit_en) begin
            case (q.st)
                ST_IDLE: begin
                    if (pay_valid && (q.pos == '0)) begin
                        d.pat = pre_pattern;
                        d.pos = POS_W'(1);
                        if (pre_en) begin
                            d.st  = ST_PRE;
                            d.tx  = pre_pattern[0];
                            d.rep = rep_last;
                        end else begin
                            d.st = ST_OPEN;
                            d.tx = FLAG[0];
                        end
                    end else if (fill_flags) begin
                        d.tx  = FLAG[sel];
                        d.pos = sel_end ? '0 : q.pos + POS_W'(1);
                    end else begin
                        d.tx  = 1'b1;
                        d.pos = '0;
                    end
                end
                ST_PRE: begin
                    d.tx = q.pat[sel];
                    if (sel_end) begin
                        d.pos = '0;
                        if (q.rep == '0) d.st = ST_OPEN;
                        else             d.rep = q.rep - CNT_W'(1);
                    end else begin
                        d.pos = q.pos + POS_W'(1);
                    end
                end
                ST_OPEN: begin
                    d.tx = FLAG[sel];
                    if (sel_end) begin
                        d.st   = ST_DATA;
                        d.pos  = POS_W'(BYTE_W);
                        d.ones = '0;
                        d.last = 1'b0;
                    end else begin
                        d.pos = q.pos + POS_W'(1);
                    end
                end
                ST_DATA: begin
                    if (stuff_due) begin
                        d.tx   = 1'b0;
                        d.ones = '0;
                    end else if (fetch_slot) begin
                        if (q.last) begin
                            d.st  = ST_CLOSE;
                            d.tx  = FLAG[0];
                            d.pos = POS_W'(1);
                        end else begin
                            ready_d = 1'b1;
                            d.pos   = POS_W'(1);
                            if (pay_valid) begin
                                d.sh   = pay_data;
                                d.tx   = pay_data[0];
                                d.last = pay_last;
                                d.ones = ones_next;
                            end else begin
                                d.st = ST_ABORT;
                                d.tx = 1'b1;
                            end
                        end
                    end else begin
                        d.tx   = q.sh[sel];
                        d.ones = ones_next;
                        d.pos  = q.pos + POS_W'(1);
                    end
                end
                ST_CLOSE: begin
                    d.tx = FLAG[sel];
                    if (sel_end) begin
                        d.st  = ST_IDLE;
                        d.pos = '0;
                    end else begin
                        d.pos = q.pos + POS_W'(1);
                    end
                end
                ST_ABORT: begin
                    d.tx = 1'b1;
                    if (q.pos == POS_W'(ABORT_LEN - 1)) begin
                        d.st  = ST_IDLE;
                        d.pos = '0;
                    end else begin
                        d.pos = q.pos + POS_W'(1);
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.tx   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_bit    = q.tx;
    assign pay_ready = ready_d;

    // R4
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    // R12
    ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> (bit_en && q.st == ST_DATA));

    // R9
    stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && stuff_due && bit_en) |=> !tx_bit);

    // R10
    abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ABORT) |-> tx_bit);

    // R2
    ones_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !fill_flags && !pay_valid && bit_en) |=> tx_bit);

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.pat));
endmodule

// File: tb/hdlc_tx_seq_tb.sv
module hdlc_tx_seq_tb;
    localparam logic [7:0] FLAG = 8'h7E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       fill_flags = 1'b0;
    logic       pre_en = 1'b0;
    logic [7:0] pre_pattern = '0;
    logic [1:0] pre_rep = '0;
    logic [7:0] pay_data = '0;
    logic       pay_valid = 1'b0;
    logic       pay_last = 1'b0;
    logic       pay_ready;
    logic       tx_bit;

    int checks = 0;
    int bad = 0;

    logic [7:0] pdata [0:15];
    int n_send = 0;
    int n_avail = 0;
    bit use_last = 1'b0;
    int idx = 0;
    bit gap_mode = 1'b0;
    bit exp_q [$];

    always #4 clk = ~clk;

    hdlc_tx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fill_flags(fill_flags),
        .pre_en(pre_en), .pre_pattern(pre_pattern), .pre_rep(pre_rep),
        .pay_data(pay_data), .pay_valid(pay_valid), .pay_last(pay_last),
        .pay_ready(pay_ready), .tx_bit(tx_bit)
    );

    task automatic fail_msg(string req, string what, int got, int exp);
        bad++;
        $display("FAIL %s: %s got=%0d exp=%0d", req, what, got, exp);
    endtask

    task automatic drive_src();
        pay_valid = (idx < n_avail);
        pay_data  = pdata[(idx < 16) ? idx : 15];
        pay_last  = use_last && (idx == n_send - 1);
    endtask

    // one bit slot; optional idle gap cycle before it (R4, R12)
    task automatic step(output logic b);
        logic prev;
        if (gap_mode) begin
            bit_en = 1'b0;
            drive_src();
            prev = tx_bit;
            @(posedge clk);
            @(negedge clk);
            checks++;
            if (tx_bit !== prev) fail_msg("R4", "tx_bit without strobe", tx_bit, prev);
            checks++;
            if (pay_ready !== 1'b0) fail_msg("R12", "pay_ready without strobe", pay_ready, 0);
        end
        bit_en = 1'b1;
        drive_src();
        #1;
        if (pay_ready && pay_valid) idx++;
        @(posedge clk);
        @(negedge clk);
        b = tx_bit;
    endtask

    task automatic build(bit pe, logic [7:0] pat, logic [1:0] code, bit fill,
                         int nb, bit ab, int lead);
        int ones;
        bit b;
        ones = 0;
        if (lead > 0) for (int i = lead; i < 8; i++) exp_q.push_back(FLAG[i]);
        if (pe) for (int c = 0; c < (1 << code); c++)
            for (int i = 0; i < 8; i++) exp_q.push_back(pat[i]);
        for (int i = 0; i < 8; i++) exp_q.push_back(FLAG[i]);
        for (int j = 0; j < (ab ? 1 : nb); j++) begin
            for (int i = 0; i < 8; i++) begin
                b = pdata[j][i];
                exp_q.push_back(b);
                ones = b ? ones + 1 : 0;
                if (ones == 5) begin
                    exp_q.push_back(1'b0);
                    ones = 0;
                end
            end
        end
        if (ab) for (int i = 0; i < 7; i++) exp_q.push_back(1'b1);
        else    for (int i = 0; i < 8; i++) exp_q.push_back(FLAG[i]);
        for (int i = 0; i < 16; i++) exp_q.push_back(fill ? FLAG[i % 8] : 1'b1);
    endtask

    task automatic run_frame(string req, bit pe, logic [7:0] pat, logic [1:0] code,
                             bit fill, int nb, bit ab, bit flip, int lead);
        logic b;
        int first_bad;
        logic got_b, exp_b;
        fill_flags  = fill;
        pre_en      = pe;
        pre_pattern = pat;
        pre_rep     = code;
        idx      = 0;
        n_send   = nb;
        n_avail  = ab ? 1 : nb;
        use_last = !ab;
        exp_q.delete();
        build(pe, pat, code, fill, nb, ab, lead);
        first_bad = -1;
        got_b = 1'b0;
        exp_b = 1'b0;
        for (int k = 0; k < exp_q.size(); k++) begin
            if (flip && k == 4) begin
                pre_pattern = ~pat;
                pre_rep     = ~code;
                pre_en      = !pe;
            end
            step(b);
            if (b !== exp_q[k] && first_bad < 0) begin
                first_bad = k;
                got_b = b;
                exp_b = exp_q[k];
            end
        end
        checks++;
        if (first_bad >= 0)
            fail_msg(req, $sformatf("stream bit %0d", first_bad), got_b, exp_b);
        if (!ab) begin
            checks++;
            if (idx != nb) fail_msg(req, "bytes taken", idx, nb);
        end
    endtask

    task automatic t_reset();
        checks++;
        if (tx_bit !== 1'b1) fail_msg("R1", "tx_bit in reset", tx_bit, 1);
        checks++;
        if (pay_ready !== 1'b0) fail_msg("R1", "pay_ready in reset", pay_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (tx_bit !== 1'b1) fail_msg("R1", "tx_bit after reset", tx_bit, 1);
    endtask

    task automatic t_idle_ones();
        logic b;
        int errs;
        fill_flags = 1'b0;
        n_avail = 0;
        idx = 0;
        errs = 0;
        for (int k = 0; k < 12; k++) begin
            step(b);
            if (b !== 1'b1) errs++;
        end
        checks++;
        if (errs != 0) fail_msg("R2", "non-one idle bits", errs, 0);
    endtask

    task automatic t_idle_flags();
        logic b;
        int errs;
        fill_flags = 1'b1;
        n_avail = 0;
        idx = 0;
        errs = 0;
        for (int k = 0; k < 16; k++) begin
            step(b);
            if (b !== FLAG[k % 8]) errs++;
        end
        checks++;
        if (errs != 0) fail_msg("R3", "flag fill bits", errs, 0);
        // three bits into a flag, then a frame must wait for the boundary (R3)
        for (int k = 0; k < 3; k++) step(b);
        pdata[0] = 8'h96;
        run_frame("R3", 1'b0, 8'h00, 2'b00, 1'b1, 1, 1'b0, 1'b0, 3);
    endtask

    task automatic t_no_preamble();
        pdata[0] = 8'hA5;
        pdata[1] = 8'h3C;
        run_frame("R5", 1'b0, 8'hC3, 2'b11, 1'b0, 2, 1'b0, 1'b0, 0);
    endtask

    task automatic t_preamble_counts();
        pdata[0] = 8'h81;
        run_frame("R6", 1'b1, 8'h55, 2'b00, 1'b0, 1, 1'b0, 1'b0, 0);
        run_frame("R6", 1'b1, 8'h0F, 2'b01, 1'b0, 1, 1'b0, 1'b0, 0);
        run_frame("R6", 1'b1, 8'h3A, 2'b10, 1'b1, 1, 1'b0, 1'b0, 0);
        run_frame("R6", 1'b1, 8'hC1, 2'b11, 1'b0, 1, 1'b0, 1'b0, 0);
    endtask

    task automatic t_preamble_no_stuff();
        pdata[0] = 8'h00;
        run_frame("R7", 1'b1, 8'hFF, 2'b01, 1'b0, 1, 1'b0, 1'b0, 0);
    endtask

    task automatic t_payload();
        pdata[0] = 8'h12;
        pdata[1] = 8'h34;
        pdata[2] = 8'h56;
        pdata[3] = 8'h78;
        run_frame("R8", 1'b0, 8'h00, 2'b00, 1'b1, 4, 1'b0, 1'b0, 0);
    endtask

    task automatic t_stuffing();
        pdata[0] = 8'hFF;
        pdata[1] = 8'hFF;
        pdata[2] = 8'h7E;
        run_frame("R9", 1'b0, 8'h00, 2'b00, 1'b0, 3, 1'b0, 1'b0, 0);
        // run crossing a byte boundary
        pdata[0] = 8'hE0;
        pdata[1] = 8'h03;
        run_frame("R9", 1'b0, 8'h00, 2'b00, 1'b1, 2, 1'b0, 1'b0, 0);
        // run of five ones ending the last byte
        pdata[0] = 8'hF8;
        run_frame("R9", 1'b1, 8'hFF, 2'b00, 1'b0, 1, 1'b0, 1'b0, 0);
    endtask

    task automatic t_abort();
        pdata[0] = 8'h0F;
        run_frame("R10", 1'b0, 8'h00, 2'b00, 1'b0, 3, 1'b1, 1'b0, 0);
        pdata[0] = 8'hF8;
        run_frame("R10", 1'b1, 8'h5A, 2'b00, 1'b1, 2, 1'b1, 1'b0, 0);
    endtask

    task automatic t_cfg_frozen();
        pdata[0] = 8'h69;
        pdata[1] = 8'h0F;
        run_frame("R11", 1'b1, 8'hA3, 2'b10, 1'b0, 2, 1'b0, 1'b1, 0);
    endtask

    task automatic t_gaps();
        gap_mode = 1'b1;
        pdata[0] = 8'h1F;
        pdata[1] = 8'hE4;
        run_frame("R4", 1'b1, 8'h6C, 2'b01, 1'b0, 2, 1'b0, 1'b0, 0);
        gap_mode = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) pdata[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        t_idle_ones();
        t_idle_flags();
        t_no_preamble();
        t_preamble_counts();
        t_preamble_no_stuff();
        t_payload();
        t_stuffing();
        t_abort();
        t_cfg_frozen();
        t_gaps();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #1600000;
        checks++;
        bad++;
        $display("FAIL watchdog: run did not finish got=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule